// File: doc/BRIEF.md
# Dynamically Sized Bus Cycle Sequencer

This block turns single 32-bit requests from a processor core into cycles on an external bus. The bus chooses the width of each cycle. Each request carries a word address, four byte enables, write data, a direction flag and two lock flags. The block drives the address strobe, byte enables, direction, lock and data pins. It samples a ready input, a 16-bit-size input and a next-address input.

A cycle can end with the size input high while the next-address input has stayed low. If enabled bytes remain in the upper half, the block runs a second, non-pipelined part without an address strobe to move them. The upper logical half then travels on the low pins. If the next-address input is seen during a cycle, the size report is ignored. The core may then hand over its following request early, which overlaps the next address with the current data phase. A lock output keeps other masters off the bus for the whole of a locked sequence. Read results from both parts are merged into a single word with one completion pulse.

States: `S_TI` (idle), `S_T1` (address phase, or first clock of part two), `S_T2` (data phase, waits for ready), `S_T2P` (data phase with the next address already driven), `S_T1P` (first clock of a cycle whose address was issued early). Transitions:
- `S_TI→S_T1` on an accepted request.
- `S_T1→S_T2` and `S_T1P→S_T2` always.
- `S_T2→S_T1` on ready when a second part is needed.
- `S_T2→S_TI` on a final ready.
- `S_T2→S_T2P` on an early accept.
- `S_T2P→S_T1P` on ready.

Top module: `dbs_seq`

## Requirements
- R1: After reset, the block is in `S_TI` with `bus_ads`, `bus_lock`, `core_done` and `bus_be` all low and `req_ready` high.
- R2: A request accepted in `S_TI` gives exactly one clock with `bus_ads` high. In that clock `bus_addr`, `bus_be` and `bus_wr` show the request. `S_T2` clocks follow until `bus_rdy` is high. `core_done` pulses for one clock in the clock after the final ready.
- R3: For a cycle ended as 32-bit, `core_rdata` equals `bus_din` sampled at ready, with every byte whose enable is low forced to zero.
- R4: A cycle ends with `bus_sz16`=1 and no next-address seen, and its enables include bytes in both bit groups 1:0 and 3:2. The block then runs a second part. In that part `bus_ads` stays low and `bus_be` equals the original enables ANDed with 4'b1100. It lasts one `S_T1` clock plus `S_T2` clocks until ready. There is no `core_done` before the second ready.
- R5: In a split read, `core_rdata` is {second-part `bus_din[15:0]`, first-part `bus_din[15:0]`}, masked by the enables.
- R6: For writes, part one drives `bus_dout` = write data and `bus_doe`=1. Part two drives `bus_dout` = {wdata[31:16], wdata[31:16]}.
- R7: With enables only in 1:0, a 16-bit response ends the transfer in one cycle. `core_rdata` is {16'h0, `bus_din[15:0]`} masked.
- R8: With enables only in 3:2, a write drives {wdata[31:16], wdata[31:16]} from the first clock. A 16-bit read ends in one cycle with `core_rdata` = {`bus_din[15:0]`, 16'h0} masked.
- R9: If `bus_na` is high in any `S_T2` clock of a first part, including the ready clock, `bus_sz16` is ignored and the cycle is treated as 32-bit.
- R10: In `S_T2` of an unlocked first part, with next-address seen and no ready, `req_ready` is high. Without next-address, `req_ready` is low. An accepted request drives its address with `bus_ads` for one clock (`S_T2P`), while the current write data stays on the pins. After ready, one `S_T1P` clock follows in which ready is ignored.
- R11: `bus_lock` rises in the address clock of the first locked transfer. It stays high across split parts and idle gaps. It falls in the clock after the ready that ends a transfer flagged `req_lock_end`.
- R12: Each accepted transfer produces exactly one `core_done` pulse, always one clock after a sampled ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_valid | input | 1 | core request present |
| req_ready | output | 1 | request accepted this clock when valid |
| req_addr | input | ADDR_W | word address |
| req_be | input | 4 | byte enables, bit n for byte n |
| req_wdata | input | 32 | write data |
| req_write | input | 1 | 1 write, 0 read |
| req_lock | input | 1 | transfer belongs to a locked sequence |
| req_lock_end | input | 1 | last transfer of the locked sequence |
| core_done | output | 1 | one-clock completion pulse |
| core_rdata | output | 32 | merged, masked read data |
| bus_addr | output | ADDR_W | bus address |
| bus_be | output | 4 | bus byte enables, active high |
| bus_ads | output | 1 | address strobe, active high |
| bus_wr | output | 1 | bus direction, 1 write |
| bus_lock | output | 1 | bus lock |
| bus_dout | output | 32 | write data pins |
| bus_doe | output | 1 | write data drive enable |
| bus_din | input | 32 | read data pins |
| bus_rdy | input | 1 | ends the current T2 |
| bus_sz16 | input | 1 | bus reports a 16-bit cycle |
| bus_na | input | 1 | next address requested |

## Verification
On every clock, the assertions check the following:
- the single-clock strobe;
- the strobe and low enables being absent in part two;
- done pulses being isolated and always tied to a ready;
- lock falling only after a ready;
- requests being accepted only in `S_TI` or `S_T2`.

Only the bench scenarios can show the data outcomes. These are the lane routing for writes, the merged read word for each enable pattern, and that the size report is ignored once next-address is seen. The same holds for the overlapped address and the ignored ready in `S_T1P`, and for lock being held across a locked read-modify-write.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int BE_W    = WORD_W / 8;
    localparam int HBE_W   = BE_W / 2;

    typedef enum logic [2:0] {
        S_TI  = 3'd0,
        S_T1  = 3'd1,
        S_T2  = 3'd2,
        S_T1P = 3'd3,
        S_T2P = 3'd4
    } bus_state_e;

    typedef struct packed {
        logic [BE_W-1:0] be;
        logic            wr;
        logic            lk;
        logic            lk_end;
    } xfer_ctl_t;
endpackage

// File: rtl/dbs_plan.sv
module dbs_plan
    import dbs_pkg::*;
(
    input  logic [BE_W-1:0] be,
    input  logic            part_hi,
    input  logic            sz16,
    input  logic            na_now,
    output logic [BE_W-1:0] be_out,
    output logic            sz_eff,
    output logic            need_hi,
    output logic            lo_only,
    output logic            up_only
);
    logic any_lo;
    logic any_up;

    always_comb begin
        any_lo  = |be[HBE_W-1:0];
        any_up  = |be[BE_W-1:HBE_W];
        lo_only = any_lo && !any_up;
        up_only = any_up && !any_lo;
        sz_eff  = sz16 && !na_now && !part_hi;
        need_hi = sz_eff && any_lo && any_up;
        if (part_hi)
            be_out = {be[BE_W-1:HBE_W], {HBE_W{1'b0}}};
        else
            be_out = be;
    end
endmodule

// File: rtl/dbs_lanes.sv
module dbs_lanes
    import dbs_pkg::*;
(
    input  logic [WORD_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    input  logic              part_hi,
    input  logic              up_only,
    input  logic              sz_eff,
    input  logic [WORD_W-1:0] din,
    input  logic [HALF_W-1:0] lo_q,
    output logic [WORD_W-1:0] dout,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] raw;

    for (genvar b = 0; b < BE_W; b++) begin : g_mask
        assign mask[b*8 +: 8] = {8{be[b]}};
    end

    always_comb begin
        if (part_hi || up_only)
            dout = {wdata[WORD_W-1:HALF_W], wdata[WORD_W-1:HALF_W]};
        else
            dout = wdata;

        if (part_hi)
            raw = {din[HALF_W-1:0], lo_q};
        else if (sz_eff && up_only)
            raw = {din[HALF_W-1:0], {HALF_W{1'b0}}};
        else if (sz_eff)
            raw = {{HALF_W{1'b0}}, din[HALF_W-1:0]};
        else
            raw = din;
        rd_word = raw & mask;
    end
endmodule

// File: rtl/dbs_lock.sv
module dbs_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic lock_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock_o <= 1'b0;
        else if (set_i)
            lock_o <= 1'b1;
        else if (clr_i)
            lock_o <= 1'b0;
    end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BE_W-1:0]     req_be,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic                req_write,
    input  logic                req_lock,
    input  logic                req_lock_end,
    output logic                core_done,
    output logic [WORD_W-1:0]   core_rdata,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [BE_W-1:0]     bus_be,
    output logic                bus_ads,
    output logic                bus_wr,
    output logic                bus_lock,
    output logic [WORD_W-1:0]   bus_dout,
    output logic                bus_doe,
    input  logic [WORD_W-1:0]   bus_din,
    input  logic                bus_rdy,
    input  logic                bus_sz16,
    input  logic                bus_na
);
    bus_state_e        state, state_nx;

    xfer_ctl_t         cur_ctl, nxt_ctl;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [WORD_W-1:0] cur_wdata, nxt_wdata;
    logic              part_hi;
    logic              na_seen;
    logic              fresh;
    logic [HALF_W-1:0] lo_q;

    logic [BE_W-1:0]   plan_be;
    logic              sz_eff, need_hi, lo_only, up_only, na_now;
    logic [WORD_W-1:0] lane_dout, rd_word;
    logic              pipe_ok, take_idle, take_pipe;
    logic              finish, split_go;
    logic              lock_set, lock_clr;

    assign na_now = na_seen || bus_na;

    dbs_plan u_plan (
        .be      (cur_ctl.be),
        .part_hi (part_hi),
        .sz16    (bus_sz16),
        .na_now  (na_now),
        .be_out  (plan_be),
        .sz_eff  (sz_eff),
        .need_hi (need_hi),
        .lo_only (lo_only),
        .up_only (up_only)
    );

    dbs_lanes u_lanes (
        .wdata   (cur_wdata),
        .be      (cur_ctl.be),
        .part_hi (part_hi),
        .up_only (up_only),
        .sz_eff  (sz_eff),
        .din     (bus_din),
        .lo_q    (lo_q),
        .dout    (lane_dout),
        .rd_word (rd_word)
    );

    // early acceptance only in an unlocked first part still waiting for ready
    assign pipe_ok   = (state == S_T2) && !part_hi && na_now && !bus_rdy && !cur_ctl.lk;
    assign req_ready = (state == S_TI) || pipe_ok;
    assign take_idle = (state == S_TI) && req_valid;
    assign take_pipe = pipe_ok && req_valid;
    assign split_go  = (state == S_T2) && bus_rdy && need_hi;
    assign finish    = ((state == S_T2) && bus_rdy && !need_hi) ||
                       ((state == S_T2P) && bus_rdy);

    assign lock_set = (take_idle && req_lock) || (take_pipe && req_lock);
    assign lock_clr = finish && cur_ctl.lk && cur_ctl.lk_end;

    dbs_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lock_set),
        .clr_i  (lock_clr),
        .lock_o (bus_lock)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_TI;
        else
            state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_TI:  if (req_valid) state_nx = S_T1;
            S_T1:  state_nx = S_T2;
            S_T1P: state_nx = S_T2;
            S_T2: begin
                if (bus_rdy)
                    state_nx = need_hi ? S_T1 : S_TI;
                else if (take_pipe)
                    state_nx = S_T2P;
            end
            S_T2P: if (bus_rdy) state_nx = S_T1P;
            default: state_nx = S_TI;
        endcase
    end

    // transfer bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ctl    <= '0;
            nxt_ctl    <= '0;
            cur_addr   <= '0;
            nxt_addr   <= '0;
            cur_wdata  <= '0;
            nxt_wdata  <= '0;
            part_hi    <= 1'b0;
            na_seen    <= 1'b0;
            fresh      <= 1'b0;
            lo_q       <= '0;
            core_done  <= 1'b0;
            core_rdata <= '0;
        end else begin
            core_done <= finish;
            if (finish)
                core_rdata <= rd_word;
            fresh <= take_pipe;

            if (take_idle) begin
                cur_ctl   <= '{be: req_be, wr: req_write, lk: req_lock, lk_end: req_lock_end};
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                part_hi   <= 1'b0;
                na_seen   <= 1'b0;
            end else if (take_pipe) begin
                nxt_ctl   <= '{be: req_be, wr: req_write, lk: req_lock, lk_end: req_lock_end};
                nxt_addr  <= req_addr;
                nxt_wdata <= req_wdata;
                na_seen   <= 1'b1;
            end else if (split_go) begin
                part_hi <= 1'b1;
                lo_q    <= bus_din[HALF_W-1:0];
            end else if ((state == S_T2) && bus_rdy) begin
                part_hi <= 1'b0;
                na_seen <= 1'b0;
            end else if ((state == S_T2P) && bus_rdy) begin
                cur_ctl   <= nxt_ctl;
                cur_addr  <= nxt_addr;
                cur_wdata <= nxt_wdata;
                na_seen   <= 1'b0;
            end else if ((state == S_T2) && !part_hi && bus_na) begin
                na_seen <= 1'b1;
            end
        end
    end

    // bus outputs
    always_comb begin
        bus_ads  = 1'b0;
        bus_addr = cur_addr;
        bus_be   = '0;
        bus_wr   = cur_ctl.wr;
        bus_dout = lane_dout;
        bus_doe  = 1'b0;
        unique case (state)
            S_TI: begin
                bus_wr = 1'b0;
            end
            S_T1: begin
                bus_ads = !part_hi;
                bus_be  = plan_be;
                bus_doe = cur_ctl.wr;
            end
            S_T2, S_T1P: begin
                bus_be  = plan_be;
                bus_doe = cur_ctl.wr;
            end
            S_T2P: begin
                bus_ads  = fresh;
                bus_addr = nxt_addr;
                bus_be   = nxt_ctl.be;
                bus_wr   = nxt_ctl.wr;
                bus_doe  = cur_ctl.wr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbs_seq_chk.sv
module dbs_seq_chk
    import dbs_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input bus_state_e      state,
    input logic            part_hi,
    input logic            bus_ads,
    input logic [BE_W-1:0] bus_be,
    input logic            bus_rdy,
    input logic            bus_lock,
    input logic            core_done,
    input logic            req_valid,
    input logic            req_ready
);
    // R2: strobe lasts one clock
    p_ads_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ads |=> !bus_ads);

    // R4: no strobe and no low enables in the second part
    p_part2_no_ads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        part_hi |-> !bus_ads);
    p_part2_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
        part_hi |-> (bus_be[HBE_W-1:0] == '0));

    // R12: isolated done pulses that follow a ready
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);
    p_done_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> $past(bus_rdy));

    // R11: lock drops only after a ready
    p_lock_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> $past(bus_rdy));

    // R10: requests taken only when idle or in a first-part T2
    p_accept_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ((state == S_TI) || (state == S_T2 && !part_hi)));
endmodule

bind dbs_seq dbs_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .part_hi   (part_hi),
    .bus_ads   (bus_ads),
    .bus_be    (bus_be),
    .bus_rdy   (bus_rdy),
    .bus_lock  (bus_lock),
    .core_done (core_done),
    .req_valid (req_valid),
    .req_ready (req_ready)
);

// File: tb/dbs_seq_bench.sv
module dbs_seq_bench;
    localparam int AW = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_lock = 1'b0;
    logic        req_lock_end = 1'b0;
    logic        core_done;
    logic [31:0] core_rdata;
    logic [AW-1:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_ads, bus_wr, bus_lock, bus_doe;
    logic [31:0] bus_dout;
    logic [31:0] bus_din = '0;
    logic        bus_rdy = 1'b0;
    logic        bus_sz16 = 1'b0;
    logic        bus_na = 1'b0;

    int checks = 0;
    int errors = 0;
    bit lock_model = 1'b0;

    always #10 clk = ~clk;

    dbs_seq #(.ADDR_W(AW)) u_dbs_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_write(req_write),
        .req_lock(req_lock), .req_lock_end(req_lock_end),
        .core_done(core_done), .core_rdata(core_rdata),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_ads(bus_ads), .bus_wr(bus_wr),
        .bus_lock(bus_lock), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_rdy(bus_rdy), .bus_sz16(bus_sz16), .bus_na(bus_na)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
        return m;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] be, input bit half, input bit split,
                                           input logic [31:0] d1, input logic [31:0] d2);
        logic [31:0] r;
        if (split)                 r = {d2[15:0], d1[15:0]};
        else if (!half)            r = d1;
        else if (be[1:0] == 2'b00) r = {d1[15:0], 16'h0};
        else                       r = {16'h0, d1[15:0]};
        return r & bmask(be);
    endfunction

    function automatic logic [31:0] exp_dout(input logic [31:0] w, input logic [3:0] be, input bit p2);
        if (p2 || be[1:0] == 2'b00) return {w[31:16], w[31:16]};
        return w;
    endfunction

    task automatic xfer(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] w,
                        input bit wr, input bit lk, input bit lke, input int waits,
                        input bit sz, input bit na, input logic [31:0] d1, input logic [31:0] d2);
        bit half, split;
        half  = sz && !na;
        split = half && (be[1:0] != 0) && (be[3:2] != 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready in idle", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1; req_addr = a; req_be = be; req_wdata = w;
        req_write = wr; req_lock = lk; req_lock_end = lke;
        @(negedge clk);
        req_valid = 1'b0;
        if (lk) lock_model = 1'b1;
        chk(bus_ads && bus_addr == a && bus_be == be && bus_wr == wr, "R2 address clock",
            {bus_ads, bus_wr, bus_be, 26'b0}, {1'b1, wr, be, 26'b0});
        chk(bus_lock == lock_model, "R11 lock in T1", {31'b0, bus_lock}, {31'b0, lock_model});
        if (wr) chk(bus_doe && bus_dout == exp_dout(w, be, 1'b0), "R6 R8 part one write lanes",
                    bus_dout, exp_dout(w, be, 1'b0));
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk(!bus_ads && !core_done, "R2 wait state", {30'b0, bus_ads, core_done}, 32'h0);
        end
        @(negedge clk);
        bus_rdy = 1'b1; bus_sz16 = sz; bus_na = na; bus_din = d1;
        @(negedge clk);
        bus_rdy = 1'b0; bus_sz16 = 1'b0; bus_na = 1'b0; bus_din = $urandom;
        if (split) begin
            chk(!bus_ads && bus_be == (be & 4'b1100) && !core_done, "R4 part two start",
                {bus_ads, core_done, 26'b0, bus_be}, {2'b0, 26'b0, be & 4'b1100});
            chk(bus_lock == lock_model, "R11 lock across split", {31'b0, bus_lock}, {31'b0, lock_model});
            if (wr) chk(bus_dout == exp_dout(w, be, 1'b1), "R6 part two write lanes",
                        bus_dout, exp_dout(w, be, 1'b1));
            @(negedge clk);
            chk(!bus_ads && !core_done, "R4 part two T2", {30'b0, bus_ads, core_done}, 32'h0);
            bus_rdy = 1'b1; bus_sz16 = 1'b1; bus_din = d2;
            @(negedge clk);
            bus_rdy = 1'b0; bus_sz16 = 1'b0;
        end
        chk(core_done == 1'b1, "R12 done after final ready", {31'b0, core_done}, 32'h1);
        if (!wr) chk(core_rdata == exp_rd(be, half, split, d1, d2),
                     split ? "R5 merged read" : (half ? "R7 R8 half read" : "R3 R9 full read"),
                     core_rdata, exp_rd(be, half, split, d1, d2));
        if (lk && lke) lock_model = 1'b0;
        chk(bus_lock == lock_model, "R11 lock after ready", {31'b0, bus_lock}, {31'b0, lock_model});
        @(negedge clk);
        chk(core_done == 1'b0, "R12 single done pulse", {31'b0, core_done}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(!bus_ads && !bus_lock && !core_done && bus_be == 4'h0 && req_ready, "R1 reset state",
            {bus_ads, bus_lock, core_done, req_ready, 24'b0, bus_be}, {3'b0, 1'b1, 28'b0});
        rst_n = 1'b1;

        // directed corner cases
        xfer(30'h100, 4'hF, 32'hA1B2C3D4, 1'b0, 0, 0, 1, 1'b0, 1'b0, 32'h11223344, 0); // R3
        xfer(30'h101, 4'hF, 32'hA1B2C3D4, 1'b0, 0, 0, 0, 1'b1, 1'b0, 32'h9999_5678, 32'h7777_1234); // R4 R5
        xfer(30'h102, 4'hE, 32'hCAFEBABE, 1'b1, 0, 0, 2, 1'b1, 1'b0, 0, 0); // R6
        xfer(30'h103, 4'h3, 32'h0, 1'b0, 0, 0, 0, 1'b1, 1'b0, 32'hFFFF_ABCD, 0); // R7
        xfer(30'h104, 4'hC, 32'h0, 1'b0, 0, 0, 0, 1'b1, 1'b0, 32'hEEEE_4321, 0); // R8
        xfer(30'h105, 4'hC, 32'h5555AAAA, 1'b1, 0, 0, 0, 1'b1, 1'b0, 0, 0); // R8 write lanes
        xfer(30'h106, 4'hF, 32'h0, 1'b0, 0, 0, 1, 1'b1, 1'b1, 32'h0BAD_F00D, 0); // R9
        // R11 locked read-modify-write, read split
        xfer(30'h200, 4'hF, 32'h0, 1'b0, 1, 0, 0, 1'b1, 1'b0, 32'h0000_1111, 32'h0000_2222);
        @(negedge clk);
        chk(bus_lock == 1'b1, "R11 lock held in gap", {31'b0, bus_lock}, 32'h1);
        xfer(30'h200, 4'hF, 32'h3333_4444, 1'b1, 1, 1, 0, 1'b0, 1'b0, 0, 0);

        // R10 address pipelining
        @(negedge clk);
        req_valid = 1'b1; req_addr = 30'h300; req_be = 4'hF; req_write = 1'b1;
        req_wdata = 32'h1234_5678; req_lock = 0; req_lock_end = 0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk); // T2, no next-address
        #1;
        chk(req_ready == 1'b0, "R10 no early accept without next-address", {31'b0, req_ready}, 32'h0);
        bus_na = 1'b1;
        req_valid = 1'b1; req_addr = 30'h301; req_be = 4'h3; req_write = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R10 early accept offered", {31'b0, req_ready}, 32'h1);
        @(negedge clk); // T2P
        req_valid = 1'b0; bus_na = 1'b0;
        chk(bus_ads && bus_addr == 30'h301 && bus_be == 4'h3 && !bus_wr, "R10 next address issued",
            {bus_ads, bus_wr, bus_be, 26'b0}, {1'b1, 1'b0, 4'h3, 26'b0});
        chk(bus_doe && bus_dout == 32'h1234_5678, "R10 current write data held", bus_dout, 32'h1234_5678);
        @(negedge clk);
        chk(!bus_ads, "R10 strobe one clock", {31'b0, bus_ads}, 32'h0);
        bus_rdy = 1'b1; bus_sz16 = 1'b1;
        @(negedge clk); // T1P, ready kept high and must be ignored
        chk(core_done == 1'b1, "R12 done for first", {31'b0, core_done}, 32'h1);
        bus_din = 32'h4444_8765; bus_sz16 = 1'b1;
        @(negedge clk); // T2 of second
        chk(core_done == 1'b0, "R10 ready ignored in T1P", {31'b0, core_done}, 32'h0);
        @(negedge clk);
        bus_rdy = 1'b0; bus_sz16 = 1'b0;
        chk(core_done && core_rdata == 32'h0000_8765, "R7 R10 pipelined half read", core_rdata, 32'h0000_8765);

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [3:0] be;
            bit lk, lke;
            be  = 4'($urandom_range(1, 15));
            lk  = ($urandom % 4) == 0;
            lke = lk ? ($urandom % 2) : 1'b0;
            xfer(AW'($urandom), be, $urandom, 1'($urandom), lk, lke, $urandom_range(0, 2),
                 1'($urandom), ($urandom % 4) == 0, $urandom, $urandom);
        end
        if (lock_model)
            xfer(30'h3FF, 4'hF, 32'h0, 1'b0, 1, 1, 0, 1'b0, 1'b0, 32'h1, 0);
        chk(bus_lock == 1'b0, "R11 lock released", {31'b0, bus_lock}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule